// File: doc/BRIEF.md
# Synchronous Serial Port Queue and Interrupt Block

This block sits between a processor bus and the shift engine of a synchronous serial port. It holds two data queues, each 16 bits wide and 8 entries deep. Software loads transmit words into one queue. Software unloads received words from the other queue. The shift engine takes transmit words from the first queue and deposits received words into the second. The same queues serve the shifter whether it runs as a clock master or as a slave. The shift engine, its clock generator and its select handling are outside this block. A small handshake stands in for them, plus a one-cycle strobe `sclk_tick` that marks each serial clock period.

The block raises four interrupt conditions:
- **Transmit** follows the transmit queue's occupancy directly.
- **Receive** follows the receive queue's occupancy directly.
- **Receive timeout** is latched. It flags receive data that has gone unread for too long.
- **Receive overrun** is latched. It flags a received word that arrived while the receive queue was full.

A mask register passes each condition onto a masked output, and one combined line ORs the masked outputs. Software clears the two latched conditions through a clear strobe. The occupancy-driven conditions have no clear; they fall when the queue level moves.

The three data streams between software and shifter use valid/ready; a transfer happens on a clock edge where both are high.
- **Bus transmit writer:** it must hold `bus_tx_valid` and `bus_tx_data` until `bus_tx_ready` is seen.
- **Bus receive reader:** it may raise `bus_rx_ready` at any time; data is taken only when `bus_rx_valid` is high.
- **Transmit word to the shifter:** it is offered only while `port_en` is 1.
- **Received words from the shifter:** these have no back-pressure. A serial shifter cannot stall, so `shf_rx_valid` is a push strobe, and a word that finds the queue full is dropped.

Top module: `ssp_fifo_irq`

## Requirements
- R1: The transmit queue stores up to DEPTH (8) words of DATA_W (16) bits and delivers them in write order on `shf_tx_data`. `bus_tx_ready` is 1 exactly when fewer than DEPTH words are held. `shf_tx_valid` is 1 exactly when `port_en` is 1 and the queue is not empty.
- R2: The receive queue stores up to DEPTH words and delivers them in arrival order on `bus_rx_data`. `bus_rx_valid` is 1 exactly when it is not empty. A `shf_rx_valid` strobe is stored only if fewer than DEPTH words are held at that edge, even when a bus read happens in the same cycle.
- R3: Interrupt vectors use bit 0 for transmit, bit 1 for receive, bit 2 for timeout and bit 3 for overrun. `irq_masked` equals `irq_raw` AND the mask register. A mask bit of 1 enables its source. A cycle with `irq_mask_wr` high loads the mask from `irq_mask_wdata`.
- R4: `irq_any` is 1 exactly when any bit of `irq_masked` is 1.
- R5: `irq_raw[0]` is 1 exactly when the transmit queue holds TX_LEVEL (4) or fewer words, whatever the value of `port_en`.
- R6: `irq_raw[1]` is 1 exactly when the receive queue holds RX_LEVEL (4) or more words. Clear bits 0 and 1 have no effect on bits 0 and 1.
- R7: `irq_raw[2]` sets after TIMEOUT_TICKS `sclk_tick` strobes with the receive queue non-empty and no receive push or pop. Every push or pop restarts the count. The flag clears on a receive pop, or on `irq_clr_wr` with bit 2 set. A new expiry wins over a clear in the same cycle.
- R8: A `shf_rx_valid` strobe while the receive queue is full discards the word and leaves the queue contents unchanged. It sets `irq_raw[3]`, which holds until `irq_clr_wr` with bit 3 set. A new overrun wins over a clear in the same cycle.
- R9: After reset both queues are empty, the mask is 0 and both latched flags are 0. So `irq_raw` reads 4'b0001 and `irq_any` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; gates offering of transmit words |
| sclk_tick | input | 1 | One-cycle strobe per serial clock period |
| bus_tx_valid | input | 1 | Bus has a transmit word |
| bus_tx_ready | output | 1 | Transmit queue can accept |
| bus_tx_data | input | DATA_W | Transmit word from bus |
| bus_rx_valid | output | 1 | Receive queue has a word |
| bus_rx_ready | input | 1 | Bus takes the receive word |
| bus_rx_data | output | DATA_W | Oldest received word |
| shf_tx_valid | output | 1 | Transmit word offered to shifter |
| shf_tx_ready | input | 1 | Shifter takes the transmit word |
| shf_tx_data | output | DATA_W | Oldest transmit word |
| shf_rx_valid | input | 1 | Shifter push strobe for a received word |
| shf_rx_data | input | DATA_W | Received word |
| irq_mask_wr | input | 1 | Mask register write strobe |
| irq_mask_wdata | input | 4 | New mask value |
| irq_clr_wr | input | 1 | Clear register write strobe |
| irq_clr_wdata | input | 4 | Clear bits (2: timeout, 3: overrun) |
| irq_raw | output | 4 | Unmasked interrupt conditions |
| irq_masked | output | 4 | Masked interrupt conditions |
| irq_any | output | 1 | OR of masked conditions |

## Verification
The bench builds the block with its default widths, depth and levels. It sets TIMEOUT_TICKS to 8, so timeout expiries, and restarts just short of expiry, happen many times in a few thousand cycles. An 8-deep queue with thresholds at 4 keeps full, empty, threshold-edge and overrun cases frequent under biased random traffic. The traffic runs in phases: port disabled, draining, receive idle, and mixed.

// File: rtl/ssp_fifo_pkg.sv
package ssp_fifo_pkg;
  localparam int IRQ_N      = 4;
  localparam int IRQ_TX     = 0;
  localparam int IRQ_RX     = 1;
  localparam int IRQ_TMO    = 2;
  localparam int IRQ_OVR    = 3;
  typedef logic [IRQ_N-1:0] irq_vec_t;
endpackage

// File: rtl/ssp_sync_fifo.sv
module ssp_sync_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wr_ptr <= bump(wr_ptr);
      if (pop_i)  rd_ptr <= bump(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign rdata_o = mem[rd_ptr];
  assign count_o = count_q;
  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push_i |-> (!full_o || pop_i)); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop_i |-> !empty_o); // R2
  AST_COUNT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (push_i == pop_i) |=> $stable(count_o)); // R1
endmodule

// File: rtl/ssp_rx_timeout.sv
module ssp_rx_timeout #(
  parameter int TICKS = 32,
  localparam int TW   = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic push_i,
  input  logic pop_i,
  input  logic empty_i,
  input  logic clr_i,
  output logic flag_o
);
  logic [TW-1:0] cnt_q;
  logic          flag_q;
  logic          restart;
  logic          expire;

  assign restart = push_i || pop_i || empty_i;
  assign expire  = tick_i && !restart && (cnt_q == TW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != TW'(TICKS))) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flag_q <= 1'b0;
    else if (expire)         flag_q <= 1'b1;
    else if (pop_i || clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_TMO_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) pop_i |=> !flag_o); // R7
  AST_TMO_NONEMPTY:   assert property (@(posedge clk) disable iff (!rst_n) $rose(flag_o) |-> !empty_i); // R7
  AST_TMO_HOLDS:      assert property (@(posedge clk) disable iff (!rst_n) (flag_o && !pop_i && !clr_i) |=> flag_o); // R7
endmodule

// File: rtl/ssp_irq_ctrl.sv
module ssp_irq_ctrl
  import ssp_fifo_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int TX_LEVEL = 4,
  parameter int RX_LEVEL = 4,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_count_i,
  input  logic [CW-1:0] rx_count_i,
  input  logic          tmo_flag_i,
  input  logic          ovr_evt_i,
  input  logic          mask_wr_i,
  input  irq_vec_t      mask_wdata_i,
  input  logic          clr_wr_i,
  input  irq_vec_t      clr_wdata_i,
  output logic          clr_tmo_o,
  output irq_vec_t      raw_o,
  output irq_vec_t      masked_o,
  output logic          any_o
);
  irq_vec_t mask_q;
  logic     ovr_q;
  logic     clr_ovr;

  assign clr_tmo_o = clr_wr_i && clr_wdata_i[IRQ_TMO];
  assign clr_ovr   = clr_wr_i && clr_wdata_i[IRQ_OVR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovr_q <= 1'b0;
    else if (ovr_evt_i) ovr_q <= 1'b1;
    else if (clr_ovr)   ovr_q <= 1'b0;
  end

  always_comb begin
    raw_o          = '0;
    raw_o[IRQ_TX]  = (tx_count_i <= CW'(TX_LEVEL));
    raw_o[IRQ_RX]  = (rx_count_i >= CW'(RX_LEVEL));
    raw_o[IRQ_TMO] = tmo_flag_i;
    raw_o[IRQ_OVR] = ovr_q;
  end

  assign masked_o = raw_o & mask_q;
  assign any_o    = |masked_o;

  AST_OVR_SETS:  assert property (@(posedge clk) disable iff (!rst_n) ovr_evt_i |=> raw_o[IRQ_OVR]); // R8
  AST_OVR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (raw_o[IRQ_OVR] && !clr_ovr) |=> raw_o[IRQ_OVR]); // R8
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (mask_wr_i && mask_wdata_i == '0) |=> !any_o); // R3
endmodule

// File: rtl/ssp_fifo_irq.sv
module ssp_fifo_irq
  import ssp_fifo_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int DEPTH         = 8,
  parameter int TX_LEVEL      = 4,
  parameter int RX_LEVEL      = 4,
  parameter int TIMEOUT_TICKS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              sclk_tick,
  input  logic              bus_tx_valid,
  output logic              bus_tx_ready,
  input  logic [DATA_W-1:0] bus_tx_data,
  output logic              bus_rx_valid,
  input  logic              bus_rx_ready,
  output logic [DATA_W-1:0] bus_rx_data,
  output logic              shf_tx_valid,
  input  logic              shf_tx_ready,
  output logic [DATA_W-1:0] shf_tx_data,
  input  logic              shf_rx_valid,
  input  logic [DATA_W-1:0] shf_rx_data,
  input  logic              irq_mask_wr,
  input  logic [3:0]        irq_mask_wdata,
  input  logic              irq_clr_wr,
  input  logic [3:0]        irq_clr_wdata,
  output logic [3:0]        irq_raw,
  output logic [3:0]        irq_masked,
  output logic              irq_any
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] tx_count, rx_count;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_push, tx_pop, rx_push, rx_pop;
  logic          ovr_evt, tmo_flag, clr_tmo;

  // transmit path: bus writes, shifter drains while enabled
  assign bus_tx_ready = !tx_full;
  assign tx_push      = bus_tx_valid && bus_tx_ready;
  assign shf_tx_valid = port_en && !tx_empty;
  assign tx_pop       = shf_tx_valid && shf_tx_ready;

  ssp_sync_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push_i(tx_push), .wdata_i(bus_tx_data),
    .pop_i(tx_pop), .rdata_o(shf_tx_data),
    .count_o(tx_count), .full_o(tx_full), .empty_o(tx_empty)
  );

  // receive path: shifter pushes without back-pressure, bus drains
  assign rx_push      = shf_rx_valid && !rx_full;
  assign ovr_evt      = shf_rx_valid && rx_full;
  assign bus_rx_valid = !rx_empty;
  assign rx_pop       = bus_rx_valid && bus_rx_ready;

  ssp_sync_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push_i(rx_push), .wdata_i(shf_rx_data),
    .pop_i(rx_pop), .rdata_o(bus_rx_data),
    .count_o(rx_count), .full_o(rx_full), .empty_o(rx_empty)
  );

  ssp_rx_timeout #(.TICKS(TIMEOUT_TICKS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .tick_i(sclk_tick),
    .push_i(rx_push), .pop_i(rx_pop), .empty_i(rx_empty),
    .clr_i(clr_tmo), .flag_o(tmo_flag)
  );

  ssp_irq_ctrl #(.DEPTH(DEPTH), .TX_LEVEL(TX_LEVEL), .RX_LEVEL(RX_LEVEL)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .tx_count_i(tx_count), .rx_count_i(rx_count),
    .tmo_flag_i(tmo_flag), .ovr_evt_i(ovr_evt),
    .mask_wr_i(irq_mask_wr), .mask_wdata_i(irq_mask_wdata),
    .clr_wr_i(irq_clr_wr), .clr_wdata_i(irq_clr_wdata),
    .clr_tmo_o(clr_tmo), .raw_o(irq_raw),
    .masked_o(irq_masked), .any_o(irq_any)
  );

  AST_RX_DROP_KEEPS:   assert property (@(posedge clk) disable iff (!rst_n) (shf_rx_valid && rx_full && !rx_pop) |=> rx_full); // R8
  AST_TX_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) (!port_en && tx_empty) |-> irq_raw[IRQ_TX]); // R5
  AST_ANY_NEEDS_MASK:  assert property (@(posedge clk) disable iff (!rst_n) irq_any |-> (irq_raw != '0)); // R4
  AST_TX_OFFER_EN:     assert property (@(posedge clk) disable iff (!rst_n) shf_tx_valid |-> port_en); // R1
endmodule

// File: tb/ssp_fifo_irq_test.sv
`timescale 1ns/100ps
module ssp_fifo_irq_test;
  localparam int DW = 16, DEPTH = 8, TO = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic port_en = 0, sclk_tick = 0, bus_tx_valid = 0, bus_rx_ready = 0;
  logic shf_tx_ready = 0, shf_rx_valid = 0, irq_mask_wr = 0, irq_clr_wr = 0;
  logic [DW-1:0] bus_tx_data = '0, shf_rx_data = '0;
  logic [3:0] irq_mask_wdata = '0, irq_clr_wdata = '0;
  logic bus_tx_ready, bus_rx_valid, shf_tx_valid, irq_any;
  logic [DW-1:0] bus_rx_data, shf_tx_data;
  logic [3:0] irq_raw, irq_masked;

  always #2.5 clk = ~clk;

  ssp_fifo_irq #(.DATA_W(DW), .DEPTH(DEPTH), .TX_LEVEL(4), .RX_LEVEL(4),
                 .TIMEOUT_TICKS(TO)) uut (.*);

  int vectors = 0, miscompares = 0, cyc = 0;
  bit done = 0;

  // behavioural reference model
  logic [DW-1:0] txq[$], rxq[$];
  int tcnt = 0;
  bit mto = 0, movr = 0;
  logic [3:0] mmask = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      automatic int txs = txq.size();
      automatic int rxs = rxq.size();
      automatic bit rpush = shf_rx_valid && rxs < DEPTH;
      automatic bit rpop  = bus_rx_ready && rxs > 0;
      automatic bit expire = sclk_tick && rxs > 0 && !rpush && !rpop && tcnt == TO - 1;
      if (port_en && shf_tx_ready && txs > 0) void'(txq.pop_front());
      if (bus_tx_valid && txs < DEPTH) txq.push_back(bus_tx_data);
      if (rpop) void'(rxq.pop_front());
      if (rpush) rxq.push_back(shf_rx_data);
      if (rpush || rpop || rxs == 0) tcnt = 0;
      else if (sclk_tick && tcnt < TO) tcnt++;
      if (expire) mto = 1;
      else if (rpop || (irq_clr_wr && irq_clr_wdata[2])) mto = 0;
      if (shf_rx_valid && rxs == DEPTH) movr = 1;
      else if (irq_clr_wr && irq_clr_wdata[3]) movr = 0;
      if (irq_mask_wr) mmask = irq_mask_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    logic [3:0] eraw;
    eraw = {movr, mto, rxq.size() >= 4, txq.size() <= 4};
    chk("R1 bus_tx_ready", bus_tx_ready, txq.size() < DEPTH);
    chk("R1 shf_tx_valid", shf_tx_valid, port_en && txq.size() > 0);
    if (txq.size() > 0) chk("R1 shf_tx_data", shf_tx_data, txq[0]);
    chk("R2 bus_rx_valid", bus_rx_valid, rxq.size() > 0);
    if (rxq.size() > 0) chk("R2 bus_rx_data", bus_rx_data, rxq[0]);
    chk("R5 irq_raw[0]", irq_raw[0], eraw[0]);
    chk("R6 irq_raw[1]", irq_raw[1], eraw[1]);
    chk("R7 irq_raw[2]", irq_raw[2], eraw[2]);
    chk("R8 irq_raw[3]", irq_raw[3], eraw[3]);
    chk("R3 irq_masked", irq_masked, eraw & mmask);
    chk("R4 irq_any", irq_any, |(eraw & mmask));
  endtask

  function automatic bit pct(int p);
    return ($urandom % 100) < p;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 irq_raw", irq_raw, 4'b0001);
    chk("R9 irq_any", irq_any, 1'b0);
    chk("R9 bus_tx_ready", bus_tx_ready, 1'b1);
    chk("R9 bus_rx_valid", bus_rx_valid, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      automatic int ph = (i / 250) % 4;
      @(negedge clk);
      cyc = i;
      compare_all();
      bus_tx_data  = DW'($urandom);
      shf_rx_data  = DW'($urandom);
      irq_mask_wr  = pct(4);
      irq_mask_wdata = 4'($urandom);
      irq_clr_wr   = pct(5);
      irq_clr_wdata  = 4'($urandom);
      case (ph)
        0: begin // port disabled, queues fill, overruns
          port_en = 0; bus_tx_valid = pct(60); shf_tx_ready = pct(50);
          shf_rx_valid = pct(60); bus_rx_ready = pct(10); sclk_tick = pct(50);
        end
        1: begin // drain
          port_en = 1; bus_tx_valid = pct(20); shf_tx_ready = pct(80);
          shf_rx_valid = pct(15); bus_rx_ready = pct(50); sclk_tick = pct(50);
        end
        2: begin // receive idle: timeout territory
          port_en = pct(50); bus_tx_valid = pct(40); shf_tx_ready = pct(40);
          shf_rx_valid = pct(4); bus_rx_ready = pct(3); sclk_tick = pct(90);
        end
        default: begin
          port_en = pct(80); bus_tx_valid = pct(50); shf_tx_ready = pct(50);
          shf_rx_valid = pct(45); bus_rx_ready = pct(40); sclk_tick = pct(60);
        end
      endcase
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule